// File: doc/BRIEF.md
# Multi-mode 8-bit PWM timer

An 8-bit timer/counter with a waveform generator driving two output-compare pins, A and B. A 3-bit mode field picks how the counter runs: free counting, clear on compare, fast PWM, or phase-correct PWM. Each PWM mode has two variants, with TOP fixed at 0xFF or taken from compare register A. The mode also decides when a written compare value becomes active (at once, or through a buffer that loads at a fixed point in the period) and at which count the overflow flag fires.

Software reaches the block through a single-cycle register write port and a combinational read port. The counter advances only on cycles where the prescaled `tick_i` input is high. Match flags and the overflow flag are sticky and are cleared by writing ones. Force-compare strobes let software drive a pin as if a match had happened, but only in the non-PWM modes.

Register addresses: 0 config (`[7:6]` pin A action, `[5:4]` pin B action, `[3]` reserved, `[2:0]` mode), 1 force strobes (`[0]` A, `[1]` B), 2 counter, 3 compare A, 4 compare B, 5 flags (`[0]` overflow, `[1]` match A, `[2]` match B). Addresses 6 and 7 are unused.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the counter, both compare registers, the config register, the flags and both pins are 0.
- R2: The counter holds on cycles with `tick_i` low. A write to address 2 loads the counter; in that cycle there is no step, no compare match and no overflow.
- R3: In mode 0, and in the reserved modes 4 and 6, the counter runs 0x00 to 0xFF and wraps to 0. Flag bit 0 is set by the tick taken while the count is 0xFF.
- R4: In mode 2 the counter goes to 0 on the tick after it equals compare A, and wraps at 0xFF when it is above compare A. Flag bit 0 is set only by the tick taken at 0xFF.
- R5: In modes 3 (TOP 0xFF) and 7 (TOP = compare A) the counter goes to 0 on the tick after TOP. Flag bit 0 is set by the tick at 0xFF in mode 3 and by the tick at TOP in mode 7.
- R6: In modes 1 (TOP 0xFF) and 5 (TOP = compare A) the counter counts up to TOP and then down to 0. Flag bit 0 is set by the tick taken at 0 while counting down.
- R7: A compare write takes effect at once in modes 0, 2, 4 and 6. In the fast PWM modes it loads the active register on the wrap to 0; in the phase-correct modes it loads at the turn at TOP. Addresses 3 and 4 read the active value.
- R8: On a tick where the counter equals active compare A (B), flag bit 1 (bit 2) is set. Flags stay set until a one is written to their bit at address 5; a set in the same cycle wins over the clear.
- R9: In non-PWM modes a match applies the channel's pin action: 01 toggle, 10 clear, 11 set. Action 00 drives the pin 0.
- R10: In fast PWM, action 10 sets the pin at the wrap and clears it on a match, and 11 does the reverse; the wrap wins when both happen on one tick. Actions 00 and 01 drive the pin 0.
- R11: In phase-correct PWM, action 10 clears the pin on a match while counting up and sets it on a match while counting down, and 11 does the reverse. Actions 00 and 01 drive the pin 0.
- R12: Writing a one to bit 0 (1) of address 2'd1 in a non-PWM mode applies pin A's (B's) action at once, sets no flag and leaves the counter alone. In PWM modes the strobe is ignored.
- R13: The read port returns config with bit 3 as 0, the strobe address as 0, counter, active compares, flags in bits [2:0], and 0 at addresses 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter clock enable from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| oc_a_o | output | 1 | Output-compare pin A |
| oc_b_o | output | 1 | Output-compare pin B |
| flags_o | output | 3 | Flags: match B, match A, overflow |

## Verification
The hardest situations to reach are the ones where two period events fall on the same tick. Examples are a compare value equal to TOP in fast PWM, where the wrap must win over the match, and a buffered compare A write in mode 5 that moves TOP at the turning point. The stimulus programs those values on purpose, and it also writes the counter above TOP in clear-on-compare mode. It then runs a long phase of random register writes, including mode changes mid-period, under a random tick pattern. A behavioural model checks the pins, the flags and the read port on every cycle.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;

  localparam logic [2:0] ADDR_CFG    = 3'd0;
  localparam logic [2:0] ADDR_STROBE = 3'd1;
  localparam logic [2:0] ADDR_CNT    = 3'd2;
  localparam logic [2:0] ADDR_CMPA   = 3'd3;
  localparam logic [2:0] ADDR_FLAGS  = 3'd5;

  typedef enum logic [1:0] {
    OM_OFF    = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_CLEAR  = 2'd2,
    OM_SET    = 2'd3
  } out_mode_e;

  typedef enum logic [2:0] {
    MODE_NORMAL   = 3'd0,
    MODE_PC_MAX   = 3'd1,
    MODE_CTC      = 3'd2,
    MODE_FAST_MAX = 3'd3,
    MODE_RSV4     = 3'd4,
    MODE_PC_CMP   = 3'd5,
    MODE_RSV6     = 3'd6,
    MODE_FAST_CMP = 3'd7
  } wave_mode_e;

  function automatic logic is_pwm(input logic [2:0] m);
    return m[0];
  endfunction

  function automatic logic is_phase(input logic [2:0] m);
    return (m == MODE_PC_MAX) || (m == MODE_PC_CMP);
  endfunction

  function automatic logic is_fast(input logic [2:0] m);
    return (m == MODE_FAST_MAX) || (m == MODE_FAST_CMP);
  endfunction

  function automatic logic top_from_a(input logic [2:0] m);
    return (m == MODE_CTC) || (m == MODE_PC_CMP) || (m == MODE_FAST_CMP);
  endfunction

endpackage

// File: rtl/pwm_timer8_counter.sv
module pwm_timer8_counter
  import pwm_timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] top_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         up_o,
  output logic         step_o,
  output logic         wrap_o,
  output logic         turn_o,
  output logic         ovf_o
);

  localparam logic [W-1:0] MAX    = '1;
  localparam logic [W-1:0] BOTTOM = '0;
  localparam logic [W-1:0] ONE    = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d;
  logic         phase, wrap, turn, bot_turn, ovf_raw;

  always_comb begin
    phase    = is_phase(mode_i);
    step_o   = tick_i & ~load_i;
    wrap     = 1'b0;
    turn     = 1'b0;
    bot_turn = 1'b0;
    cnt_d    = cnt_q;
    up_d     = up_q;
    if (phase) begin
      if (up_q) begin
        if (cnt_q >= top_i) begin
          turn  = 1'b1;
          up_d  = 1'b0;
          cnt_d = (cnt_q == BOTTOM) ? BOTTOM : cnt_q - ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (cnt_q == BOTTOM) begin
        bot_turn = 1'b1;
        up_d     = 1'b1;
        cnt_d    = (top_i == BOTTOM) ? BOTTOM : ONE;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end else begin
      up_d = 1'b1;
      if (cnt_q == top_i || cnt_q == MAX) begin
        wrap  = 1'b1;
        cnt_d = BOTTOM;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
    if (phase)                        ovf_raw = bot_turn;
    else if (mode_i == MODE_FAST_CMP) ovf_raw = (cnt_q == top_i);
    else                              ovf_raw = (cnt_q == MAX);
  end

  assign wrap_o = step_o & wrap;
  assign turn_o = step_o & turn;
  assign ovf_o  = step_o & ovf_raw;
  assign cnt_o  = cnt_q;
  assign up_o   = up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= BOTTOM;
      up_q  <= 1'b1;
    end else begin
      if (load_i)      cnt_q <= load_val_i;
      else if (step_o) cnt_q <= cnt_d;
      if (!phase)      up_q <= 1'b1;
      else if (step_o) up_q <= up_d;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q)); // R2
  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i))); // R2
  AST_CTC_BELOW_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CTC && step_o && cnt_q <= top_i) |=> (cnt_q <= $past(top_i))); // R4
  AST_PHASE_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_phase(mode_i) && step_o && top_i != BOTTOM)
      |=> (cnt_q == $past(cnt_q) + ONE || cnt_q == $past(cnt_q) - ONE)); // R6

endmodule

// File: rtl/pwm_timer8_chan.sv
module pwm_timer8_chan
  import pwm_timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   mode_i,
  input  logic [1:0]   om_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         upd_i,
  input  logic         step_i,
  input  logic [W-1:0] cnt_i,
  input  logic         up_i,
  input  logic         wrap_i,
  input  logic         force_i,
  output logic [W-1:0] cmp_o,
  output logic         match_o,
  output logic         oc_o
);

  logic [W-1:0] buf_q, cmp_q;
  logic         pin_q, pin_d;
  logic         pwm, fast;

  assign pwm     = is_pwm(mode_i);
  assign fast    = is_fast(mode_i);
  assign match_o = step_i && (cnt_i == cmp_q);
  assign cmp_o   = cmp_q;
  assign oc_o    = (om_i == OM_OFF || (pwm && om_i == OM_TOGGLE)) ? 1'b0 : pin_q;

  always_comb begin
    pin_d = pin_q;
    if (!pwm) begin
      if (force_i || match_o) begin
        case (om_i)
          OM_TOGGLE: pin_d = ~pin_q;
          OM_CLEAR:  pin_d = 1'b0;
          OM_SET:    pin_d = 1'b1;
          default:   pin_d = pin_q;
        endcase
      end
    end else if (fast) begin
      // wrap has priority so compare == TOP gives a steady level
      if (om_i == OM_CLEAR) begin
        if (wrap_i)       pin_d = 1'b1;
        else if (match_o) pin_d = 1'b0;
      end else if (om_i == OM_SET) begin
        if (wrap_i)       pin_d = 1'b0;
        else if (match_o) pin_d = 1'b1;
      end
    end else if (match_o) begin
      if (om_i == OM_CLEAR)    pin_d = ~up_i;
      else if (om_i == OM_SET) pin_d = up_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      cmp_q <= '0;
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
      if (wr_i) begin
        buf_q <= wr_data_i;
        if (!pwm)       cmp_q <= wr_data_i;
        else if (upd_i) cmp_q <= buf_q;
      end else if (upd_i) begin
        cmp_q <= buf_q;
      end
    end
  end

  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm && !upd_i) |=> $stable(cmp_q)); // R7
  AST_PWM_FORCE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm && force_i && !match_o && !wrap_i) |=> $stable(pin_q)); // R12
  AST_PIN_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && !match_o && !wrap_i) |=> $stable(pin_q)); // R9

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [2:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [2:0]   rd_addr_i,
  output logic [W-1:0] rd_data_o,
  output logic         oc_a_o,
  output logic         oc_b_o,
  output logic [2:0]   flags_o
);

  localparam int NUM_CH = 2;
  localparam int FLAG_W = NUM_CH + 1;
  localparam logic [W-1:0] MAX = '1;

  logic [2:0]        mode_q;
  logic [1:0]        om_q [NUM_CH];
  logic [FLAG_W-1:0] flags_q, flag_set, flag_clr;

  logic [W-1:0]      cnt, top_val;
  logic              up, step, wrap, turn, ovf, upd;
  logic [W-1:0]      cmp [NUM_CH];
  logic [NUM_CH-1:0] match, oc;
  logic              cnt_load, cfg_wr, strobe_wr, force_any;

  assign cfg_wr    = wr_en_i && (wr_addr_i == ADDR_CFG);
  assign cnt_load  = wr_en_i && (wr_addr_i == ADDR_CNT);
  assign strobe_wr = wr_en_i && (wr_addr_i == ADDR_STROBE);
  assign force_any = strobe_wr && (|wr_data_i[NUM_CH-1:0]);
  assign top_val   = top_from_a(mode_q) ? cmp[0] : MAX;
  assign upd       = is_fast(mode_q) ? wrap : (is_phase(mode_q) ? turn : 1'b0);

  pwm_timer8_counter #(.W(W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .mode_i     (mode_q),
    .top_i      (top_val),
    .load_i     (cnt_load),
    .load_val_i (wr_data_i),
    .cnt_o      (cnt),
    .up_o       (up),
    .step_o     (step),
    .wrap_o     (wrap),
    .turn_o     (turn),
    .ovf_o      (ovf)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam logic [2:0] CMP_ADDR = ADDR_CMPA + 3'(ch);
    pwm_timer8_chan #(.W(W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode_q),
      .om_i      (om_q[ch]),
      .wr_i      (wr_en_i && (wr_addr_i == CMP_ADDR)),
      .wr_data_i (wr_data_i),
      .upd_i     (upd),
      .step_i    (step),
      .cnt_i     (cnt),
      .up_i      (up),
      .wrap_i    (wrap),
      .force_i   (strobe_wr && wr_data_i[ch]),
      .cmp_o     (cmp[ch]),
      .match_o   (match[ch]),
      .oc_o      (oc[ch])
    );
  end

  assign oc_a_o   = oc[0];
  assign oc_b_o   = oc[1];
  assign flag_set = {match, ovf};
  assign flag_clr = (wr_en_i && wr_addr_i == ADDR_FLAGS) ? wr_data_i[FLAG_W-1:0] : '0;
  assign flags_o  = flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_NORMAL;
      om_q[0] <= OM_OFF;
      om_q[1] <= OM_OFF;
      flags_q <= '0;
    end else begin
      flags_q <= (flags_q & ~flag_clr) | flag_set;
      if (cfg_wr) begin
        mode_q  <= wr_data_i[2:0];
        om_q[1] <= wr_data_i[5:4];
        om_q[0] <= wr_data_i[7:6];
      end
    end
  end

  always_comb begin
    case (rd_addr_i)
      ADDR_CFG:       rd_data_o = W'({om_q[0], om_q[1], 1'b0, mode_q});
      ADDR_CNT:       rd_data_o = cnt;
      ADDR_CMPA:      rd_data_o = cmp[0];
      ADDR_CMPA + 1:  rd_data_o = cmp[1];
      ADDR_FLAGS:     rd_data_o = W'(flags_q);
      default:        rd_data_o = '0;
    endcase
  end

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_q & ~flag_clr) != '0)
      |=> ((flags_q & $past(flags_q & ~flag_clr)) == $past(flags_q & ~flag_clr))); // R8
  AST_FORCE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_any && !tick_i) |=> $stable(flags_q)); // R12
  AST_FORCE_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_any && !tick_i) |=> $stable(cnt)); // R12

endmodule

// File: tb/pwm_timer8_bench.sv
module pwm_timer8_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] rd_addr = 3'd2;
  logic [7:0] rd_data;
  logic       oc_a, oc_b;
  logic [2:0] flags;

  int checks = 0;
  int errors = 0;
  int tick_mode = 3;
  bit run = 0;

  always #10 clk = ~clk;

  pwm_timer8 u_pwm_timer8 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .oc_a_o(oc_a), .oc_b_o(oc_b), .flags_o(flags)
  );

  // reference model state
  int m_mode, m_cnt, m_flags;
  bit m_up;
  int m_om[2], m_act[2], m_buf[2], m_pin[2];

  function automatic int pin_nx(int pin, int om, int mode, bit match, bit up, bit wrap, bit frc);
    int p = pin;
    if (mode % 2 == 0) begin
      if (frc || match) begin
        case (om)
          1: p = 1 - pin;
          2: p = 0;
          3: p = 1;
          default: p = pin;
        endcase
      end
    end else if (mode == 3 || mode == 7) begin
      if (om == 2) begin
        if (wrap) p = 1; else if (match) p = 0;
      end else if (om == 3) begin
        if (wrap) p = 0; else if (match) p = 1;
      end
    end else if (match) begin
      if (om == 2) p = up ? 0 : 1;
      else if (om == 3) p = up ? 1 : 0;
    end
    return p;
  endfunction

  function automatic int m_oc(int ch);
    if (m_om[ch] == 0 || (m_mode % 2 == 1 && m_om[ch] == 1)) return 0;
    return m_pin[ch];
  endfunction

  function automatic int m_rd(int a);
    case (a)
      0: return (m_om[0] << 6) | (m_om[1] << 4) | m_mode;
      2: return m_cnt;
      3: return m_act[0];
      4: return m_act[1];
      5: return m_flags;
      default: return 0;
    endcase
  endfunction

  function automatic string cnt_tag(int mode);
    case (mode)
      2: return "R4";
      3, 7: return "R5";
      1, 5: return "R6";
      default: return "R3";
    endcase
  endfunction

  function automatic string pin_tag(int mode);
    if (mode % 2 == 0) return "R9";
    if (mode == 3 || mode == 7) return "R10";
    return "R11";
  endfunction

  always @(posedge clk) begin : model
    int top, ncnt, clr, set, d;
    bit pw, ph, fa, ld, step, wrap, turn, bot, ovf, upd, nup;
    bit mt[2];
    bit frc[2];
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_flags = 0; m_up = 1;
      for (int c = 0; c < 2; c++) begin
        m_om[c] = 0; m_act[c] = 0; m_buf[c] = 0; m_pin[c] = 0;
      end
    end else begin
      d    = int'(wr_data);
      pw   = (m_mode % 2 == 1);
      ph   = (m_mode == 1 || m_mode == 5);
      fa   = (m_mode == 3 || m_mode == 7);
      top  = (m_mode == 2 || m_mode == 5 || m_mode == 7) ? m_act[0] : 255;
      ld   = wr_en && wr_addr == 3'd2;
      step = tick && !ld;
      wrap = 0; turn = 0; bot = 0; nup = m_up; ncnt = m_cnt;
      if (ph) begin
        if (m_up) begin
          if (m_cnt >= top) begin turn = 1; nup = 0; ncnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
          else ncnt = m_cnt + 1;
        end else if (m_cnt == 0) begin
          bot = 1; nup = 1; ncnt = (top == 0) ? 0 : 1;
        end else ncnt = m_cnt - 1;
      end else begin
        if (m_cnt == top || m_cnt == 255) begin wrap = 1; ncnt = 0; end
        else ncnt = m_cnt + 1;
      end
      if (ph) ovf = bot;
      else if (m_mode == 7) ovf = (m_cnt == top);
      else ovf = (m_cnt == 255);
      ovf  = ovf && step;
      wrap = wrap && step;
      turn = turn && step;
      upd  = fa ? wrap : (ph ? turn : 0);
      for (int c = 0; c < 2; c++) begin
        mt[c]  = step && (m_cnt == m_act[c]);
        frc[c] = wr_en && wr_addr == 3'd1 && wr_data[c];
        m_pin[c] = pin_nx(m_pin[c], m_om[c], m_mode, mt[c], m_up, wrap, frc[c]);
        if (wr_en && int'(wr_addr) == 3 + c) begin
          if (!pw) m_act[c] = d;
          else if (upd) m_act[c] = m_buf[c];
          m_buf[c] = d;
        end else if (upd) m_act[c] = m_buf[c];
      end
      clr = (wr_en && wr_addr == 3'd5) ? (d & 7) : 0;
      set = (ovf ? 1 : 0) | (mt[0] ? 2 : 0) | (mt[1] ? 4 : 0);
      m_flags = ((m_flags & ~clr) | set) & 7;
      if (ld) m_cnt = d;
      else if (step) m_cnt = ncnt;
      if (!ph) m_up = 1;
      else if (step) m_up = nup;
      if (wr_en && wr_addr == 3'd0) begin
        m_mode = d & 7; m_om[1] = (d >> 4) & 3; m_om[0] = (d >> 6) & 3;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from both edges
  always @(negedge clk) begin
    #2;
    if (run) begin
      chk(rd_addr == 3'd2 ? cnt_tag(m_mode) : "R13", int'(rd_data), m_rd(int'(rd_addr)));
      chk({pin_tag(m_mode), " pin A"}, int'(oc_a), m_oc(0));
      chk({pin_tag(m_mode), " pin B"}, int'(oc_b), m_oc(1));
      chk("R8", int'(flags), m_flags);
    end
  end

  always @(negedge clk) begin
    case (tick_mode)
      0: tick = 1'b1;
      1: tick = ~tick;
      2: tick = 1'($urandom % 2);
      default: tick = 1'b0;
    endcase
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    int held, pa, pb, fl;
    idle(4);
    rst_n = 1'b1;
    run = 1;
    idle(1);
    #3;
    chk("R1 cnt", int'(rd_data), 0);
    chk("R1 pins", int'({oc_a, oc_b}), 0);
    chk("R1 flags", int'(flags), 0);
    rd_addr = 3'd0; #1; chk("R1 cfg", int'(rd_data), 0);
    rd_addr = 3'd3; #1; chk("R1 cmpA", int'(rd_data), 0);
    rd_addr = 3'd2;
    idle(1);

    // normal mode: A toggles, B sets
    wr(3, 8'h10); wr(4, 8'h80);
    wr(0, (1 << 6) | (3 << 4) | 0);
    tick_mode = 0;
    idle(600);
    wr(5, 7);
    idle(300);

    // reserved mode with bit 3 written
    wr(0, (2 << 6) | (1 << 4) | 8 | 4);
    rd_addr = 3'd0; idle(1);
    chk("R13 cfg bit3", int'(rd_data), (2 << 6) | (1 << 4) | 4);
    rd_addr = 3'd1; #1; chk("R13 strobe reads 0", int'(rd_data), 0);
    rd_addr = 3'd7; #1; chk("R13 unused addr", int'(rd_data), 0);
    rd_addr = 3'd2;
    idle(300);

    // clear on compare, then counter loaded above TOP
    wr(3, 8'h20);
    wr(0, (1 << 6) | (2 << 4) | 2);
    idle(200);
    wr(2, 8'hF0);
    idle(100);
    tick_mode = 3; idle(2);
    pa = int'(oc_a); fl = int'(flags); held = int'(rd_data);
    wr(1, 3);
    #3;
    chk("R12 force toggles A", int'(oc_a), 1 - pa);
    chk("R12 force sets no flag", int'(flags), fl);
    chk("R12 force keeps counter", int'(rd_data), held);

    // tick gating
    idle(5);
    chk("R2 counter holds without tick", int'(rd_data), held);

    // fast PWM, TOP 0xFF, B compare at TOP
    tick_mode = 1;
    wr(3, 8'h40); wr(4, 8'hFF);
    wr(0, (2 << 6) | (3 << 4) | 3);
    idle(700);
    tick_mode = 3; idle(2);
    wr(3, 8'h90);
    rd_addr = 3'd3; #3;
    chk("R7 buffered write not yet active", int'(rd_data), 8'h40);
    rd_addr = 3'd2;
    tick_mode = 1;
    idle(700);
    rd_addr = 3'd3; #3;
    chk("R7 buffer loaded at wrap", int'(rd_data), 8'h90);
    rd_addr = 3'd2;

    // fast PWM, TOP from compare A; A compare equals TOP
    tick_mode = 0;
    wr(3, 8'h30); wr(4, 8'h10);
    wr(0, (2 << 6) | (2 << 4) | 7);
    idle(600);

    // phase correct, TOP 0xFF
    wr(3, 8'h80); wr(4, 8'h00);
    wr(0, (2 << 6) | (3 << 4) | 1);
    idle(1200);
    tick_mode = 3; idle(2);
    pa = int'(oc_a); pb = int'(oc_b);
    wr(1, 3);
    #3;
    chk("R12 strobe ignored in PWM A", int'(oc_a), pa);
    chk("R12 strobe ignored in PWM B", int'(oc_b), pb);

    // phase correct, TOP from compare A, TOP moved mid-run
    tick_mode = 2;
    wr(3, 8'h40); wr(4, 8'h20);
    wr(0, (2 << 6) | (2 << 4) | 5);
    idle(800);
    wr(3, 8'h60);
    idle(800);

    // random register traffic
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 8 == 0) wr(int'($urandom % 6), int'($urandom % 256));
      else idle(1);
    end

    run = 0;
    idle(1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule